// File: doc/BRIEF.md
# Debug Instruction Injection Controller

This block sits on the debug side of a multithreaded core. It lets an external debugger place one instruction into a hardware thread that has been halted, and then read back what that instruction produced. The debugger reaches it through a simple register port that carries a write strobe, an 8-bit address and 64-bit data. The read path is combinational. The block holds the per-thread stop bits, a global injection enable, a combined command/status register and a 64-bit result register. The result register can be read whole, or as a low half and a high half.

One write to the command register supplies the instruction word, the injection-mode bit, the target thread and the execute bit. If execute is set, that same write launches the injection. A launch is accepted only under four conditions:
- injection is enabled;
- the mode bit is set;
- the thread number exists;
- the core reports that thread as not running.

An accepted launch drives a valid/ready request toward the core. It then waits for a completion strobe, which carries either a result or an exception flag. The debugger polls the done bit and a two-bit error field. A refused launch, a launch made while another is outstanding, and an exception each leave a distinct error code.

The control state machine has three states:
- `ST_IDLE`: no injection is outstanding.
- `ST_ISSUE`: the request is presented to the core.
- `ST_WAIT`: the core has taken the request and a completion is pending.

Its transitions are:
- **launch** (`ST_IDLE` to `ST_ISSUE`): an accepted execute write.
- **handoff** (`ST_ISSUE` to `ST_WAIT`): the request is valid and the core is ready.
- **finish** (`ST_WAIT` to `ST_IDLE`): a completion strobe arrives.

Top module: `dbg_inject_ctrl`

## Requirements
- R1: After reset every stored register is zero. This covers the stop bits, the enable, the command fields, the done bit, the error field and the result. No request is presented to the core.
- R2: Thread control sits at address 0x20.
  - A write to this address sets `thr_stop[i]` from data bit i.
  - A read returns the stop bits in bits [NTHREADS-1:0] and the `thr_running` inputs in bits [8+NTHREADS-1:8].
- R3: The global injection enable is bit 30 of address 0x21, so a write of 0x0000_0000_4000_0000 enables injection. The bit reads back at the same position.
- R4: Command/status sits at address 0x22, with these fields:
  - instruction word in bits [63:32];
  - mode in bit 8;
  - thread select in bits [5:4];
  - execute in bit 3.

  An accepted execute write raises `inj_valid` on the next cycle, with that instruction and thread. `inj_valid`, `inj_insn` and `inj_tid` stay stable until `inj_ready` is sampled high.
- R5: An execute write is refused if any of the following holds: mode is 0, injection is disabled, the thread select is NTHREADS or above, or the selected thread is running. A refused write issues no request and sets the error field to 01 and done to 1. The result is left unchanged.
- R6: A read of 0x22 returns done in bit 0 and the error field in bits [2:1]. An accepted execute clears done. A completion without exception then stores its data in the result register, sets done to 1 and sets the error field to 00.
- R7: A completion that flags an exception sets the error field to 11 and done to 1. It leaves the result register unchanged.
- R8: An execute write made while an injection is outstanding is ignored, and the error field becomes 10. The outstanding request keeps its instruction, and done stays 0 until its completion arrives.
- R9: The result register can be read three ways:
  - at 0x2E as all 64 bits;
  - at 0x2F as {32'b0, result[31:0]};
  - at 0x2D as {32'b0, result[63:32]}.

  Writes to these addresses load all of the result, its low half or its high half respectively.
- R10: A completion strobe that arrives while no injection is outstanding changes neither the status nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the addressed register (combinational) |
| thr_stop | output | NTHREADS | Stop request per thread |
| thr_running | input | NTHREADS | Running status per thread, from the core |
| inj_valid | output | 1 | Injection request valid |
| inj_ready | input | 1 | Core accepts the request |
| inj_insn | output | 32 | Instruction word to inject |
| inj_tid | output | 2 | Target thread |
| cmp_valid | input | 1 | Completion strobe from the core |
| cmp_data | input | 64 | Result carried with the completion |
| cmp_exc | input | 1 | Completion reports an exception |

## Verification
The assertions check the following on every cycle:
- a request is never valid while done is set;
- a request holds its instruction and thread until it is taken;
- a refused or overlapping execute write leaves the expected error code on the next cycle;
- an exception never alters the result;
- the low-half view always reads zero in its upper word.

The bench's scenarios are needed for the rest:
- that results land in the correct halves;
- that a running or non-existent thread is refused;
- that a second execute does not disturb the first injection's outcome;
- that a completion with nothing outstanding is ignored.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 64;
    localparam int INSN_W = 32;

    localparam logic [ADDR_W-1:0] A_THREAD  = 8'h20;
    localparam logic [ADDR_W-1:0] A_CFG     = 8'h21;
    localparam logic [ADDR_W-1:0] A_CMD     = 8'h22;
    localparam logic [ADDR_W-1:0] A_RES_HI  = 8'h2D;
    localparam logic [ADDR_W-1:0] A_RES     = 8'h2E;
    localparam logic [ADDR_W-1:0] A_RES_LO  = 8'h2F;

    localparam int EN_BIT    = 30;
    localparam int EXEC_BIT  = 3;
    localparam int TID_LSB   = 4;
    localparam int MODE_BIT  = 8;
    localparam int RUN_LSB   = 8;
    localparam int INSN_LSB  = 32;

    localparam logic [1:0] ERR_OK      = 2'b00;
    localparam logic [1:0] ERR_REFUSED = 2'b01;
    localparam logic [1:0] ERR_BUSY    = 2'b10;
    localparam logic [1:0] ERR_EXC     = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } inj_state_t;
endpackage

// File: rtl/dbg_thread_ctl.sv
module dbg_thread_ctl
    import dbg_inject_pkg::*;
#(
    parameter int NTHREADS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_thr,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    output logic [NTHREADS-1:0] stop_q,
    output logic              en_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (wr_thr) stop_q <= wdata[NTHREADS-1:0];
            if (wr_cfg) en_q   <= wdata[EN_BIT];
        end
    end
endmodule

// File: rtl/dbg_result_reg.sv
module dbg_result_reg
    import dbg_inject_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_full,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic [DATA_W-1:0] res_q
);
    localparam int HALF = DATA_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (cap_en) begin
            res_q <= cap_data;
        end else if (wr_full) begin
            res_q <= wdata;
        end else begin
            if (wr_lo) res_q[HALF-1:0]      <= wdata[HALF-1:0];
            if (wr_hi) res_q[DATA_W-1:HALF] <= wdata[HALF-1:0];
        end
    end
endmodule

// File: rtl/dbg_inject_fsm.sv
module dbg_inject_fsm
    import dbg_inject_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exec_req,
    input  logic       launch_ok,
    input  logic       inj_ready,
    input  logic       cmp_valid,
    input  logic       cmp_exc,
    output logic       inj_valid,
    output logic       busy,
    output logic       cap_en,
    output logic       done,
    output logic [1:0] err
);
    inj_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        inj_valid = 1'b0;
        busy      = 1'b1;
        cap_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (exec_req && launch_ok) state_d = ST_ISSUE;   // launch
            end
            ST_ISSUE: begin
                inj_valid = 1'b1;
                if (inj_ready) state_d = ST_WAIT;                // handoff
            end
            ST_WAIT: begin
                if (cmp_valid) begin                             // finish
                    cap_en  = !cmp_exc;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // status: done bit and error code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= ERR_OK;
        end else begin
            if (state_q == ST_WAIT && cmp_valid) begin
                done <= 1'b1;
                err  <= cmp_exc ? ERR_EXC : ERR_OK;
            end
            if (exec_req) begin
                if (busy) begin
                    err <= ERR_BUSY;
                end else if (!launch_ok) begin
                    done <= 1'b1;
                    err  <= ERR_REFUSED;
                end else begin
                    done <= 1'b0;
                    err  <= ERR_OK;
                end
            end
        end
    end
endmodule

// File: rtl/dbg_inject_ctrl.sv
module dbg_inject_ctrl
    import dbg_inject_pkg::*;
#(
    parameter int NTHREADS = 3,
    parameter int TID_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NTHREADS-1:0] thr_stop,
    input  logic [NTHREADS-1:0] thr_running,
    output logic                inj_valid,
    input  logic                inj_ready,
    output logic [INSN_W-1:0]   inj_insn,
    output logic [TID_W-1:0]    inj_tid,
    input  logic                cmp_valid,
    input  logic [DATA_W-1:0]   cmp_data,
    input  logic                cmp_exc
);
    localparam int HALF = DATA_W / 2;

    logic              wr_thr, wr_cfg, wr_cmd, wr_full, wr_lo, wr_hi;
    logic              inj_en, exec_req, launch_ok, busy, cap_en, done;
    logic              tgt_running;
    logic [1:0]        err;
    logic [DATA_W-1:0] res_q;
    logic [INSN_W-1:0] insn_q;
    logic [TID_W-1:0]  tid_q;
    logic              mode_q;
    logic [TID_W-1:0]  wr_tid;

    assign wr_thr  = reg_wr && reg_addr == A_THREAD;
    assign wr_cfg  = reg_wr && reg_addr == A_CFG;
    assign wr_cmd  = reg_wr && reg_addr == A_CMD;
    assign wr_full = reg_wr && reg_addr == A_RES;
    assign wr_lo   = reg_wr && reg_addr == A_RES_LO;
    assign wr_hi   = reg_wr && reg_addr == A_RES_HI;

    assign wr_tid   = reg_wdata[TID_LSB +: TID_W];
    assign exec_req = wr_cmd && reg_wdata[EXEC_BIT];

    // a thread number outside the implemented range counts as running
    always_comb begin
        tgt_running = 1'b1;
        for (int i = 0; i < NTHREADS; i++)
            if (wr_tid == TID_W'(i)) tgt_running = thr_running[i];
    end

    assign launch_ok = reg_wdata[MODE_BIT] && inj_en && !tgt_running;

    // command fields; frozen while an injection is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q <= '0;
            tid_q  <= '0;
            mode_q <= 1'b0;
        end else if (wr_cmd && !busy) begin
            insn_q <= reg_wdata[INSN_LSB +: INSN_W];
            tid_q  <= wr_tid;
            mode_q <= reg_wdata[MODE_BIT];
        end
    end

    assign inj_insn = insn_q;
    assign inj_tid  = tid_q;

    dbg_thread_ctl #(.NTHREADS(NTHREADS)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_thr (wr_thr),
        .wr_cfg (wr_cfg),
        .wdata  (reg_wdata),
        .stop_q (thr_stop),
        .en_q   (inj_en)
    );

    dbg_inject_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_req  (exec_req),
        .launch_ok (launch_ok),
        .inj_ready (inj_ready),
        .cmp_valid (cmp_valid),
        .cmp_exc   (cmp_exc),
        .inj_valid (inj_valid),
        .busy      (busy),
        .cap_en    (cap_en),
        .done      (done),
        .err       (err)
    );

    dbg_result_reg u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_full  (wr_full),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (reg_wdata),
        .cap_en   (cap_en),
        .cap_data (cmp_data),
        .res_q    (res_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_THREAD: begin
                reg_rdata[NTHREADS-1:0]        = thr_stop;
                reg_rdata[RUN_LSB +: NTHREADS] = thr_running;
            end
            A_CFG:    reg_rdata[EN_BIT] = inj_en;
            A_CMD: begin
                reg_rdata[INSN_LSB +: INSN_W] = insn_q;
                reg_rdata[MODE_BIT]           = mode_q;
                reg_rdata[TID_LSB +: TID_W]   = tid_q;
                reg_rdata[2:1]                = err;
                reg_rdata[0]                  = done;
            end
            A_RES:    reg_rdata = res_q;
            A_RES_LO: reg_rdata[HALF-1:0] = res_q[HALF-1:0];
            A_RES_HI: reg_rdata[HALF-1:0] = res_q[DATA_W-1:HALF];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbg_inject_chk.sv
module dbg_inject_chk
    import dbg_inject_pkg::*;
#(
    parameter int TID_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              inj_valid,
    input logic              inj_ready,
    input logic [INSN_W-1:0] inj_insn,
    input logic [TID_W-1:0]  inj_tid,
    input logic              cmp_valid,
    input logic              cmp_exc,
    input logic              inj_en,
    input logic              busy,
    input logic              done,
    input logic [1:0]        err,
    input logic [DATA_W-1:0] res_q
);
    logic exec_w;
    assign exec_w = reg_wr && reg_addr == A_CMD && reg_wdata[EXEC_BIT];

    assert_req_not_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !done);

    assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_ready) |=> (inj_valid && $stable(inj_insn) && $stable(inj_tid)));

    assert_refuse_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && !busy && !inj_en) |=> (done && err == ERR_REFUSED && !inj_valid));

    assert_busy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && busy) |=> (err == ERR_BUSY));

    assert_exc_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inj_valid && cmp_valid && cmp_exc && !reg_wr) |=> (err == ERR_EXC && done && $stable(res_q)));

    assert_lo_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_RES_LO) |-> (reg_rdata[63:32] == 32'h0));
endmodule

bind dbg_inject_ctrl dbg_inject_chk #(.TID_W(TID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .inj_valid (inj_valid),
    .inj_ready (inj_ready),
    .inj_insn  (inj_insn),
    .inj_tid   (inj_tid),
    .cmp_valid (cmp_valid),
    .cmp_exc   (cmp_exc),
    .inj_en    (inj_en),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .res_q     (res_q)
);

// File: tb/tb_dbg_inject_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_inject_ctrl;
    localparam int NT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [NT-1:0] thr_stop, thr_running, run_d1;
    logic        inj_valid, inj_ready;
    logic [31:0] inj_insn;
    logic [1:0]  inj_tid;
    logic        cmp_valid, cmp_exc;
    logic [63:0] cmp_data;

    logic        core_cmp = 1'b0, core_exc = 1'b0, core_busy = 1'b0;
    logic [63:0] core_data = '0;
    logic [31:0] core_insn = '0;
    logic [1:0]  core_tid = '0;
    int          core_cnt = 0;
    int          core_lat = 3;
    logic        stray_cmp = 1'b0;
    int          req_count = 0;
    logic        rdy_q = 1'b0;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    dbg_inject_ctrl #(.NTHREADS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .thr_stop(thr_stop),
        .thr_running(thr_running), .inj_valid(inj_valid), .inj_ready(inj_ready),
        .inj_insn(inj_insn), .inj_tid(inj_tid), .cmp_valid(cmp_valid),
        .cmp_data(cmp_data), .cmp_exc(cmp_exc)
    );

    function automatic logic [63:0] core_res(logic [31:0] i, logic [1:0] t);
        return {i ^ 32'hA5A5_5A5A, ~i} + 64'(t);
    endfunction

    function automatic logic [63:0] cmd_word(logic [31:0] i, logic [1:0] t, logic m, logic x);
        logic [63:0] w;
        w = '0; w[63:32] = i; w[8] = m; w[5:4] = t; w[3] = x;
        return w;
    endfunction

    // stand-in core: threads stop two cycles after request, fixed-latency completion
    always_ff @(posedge clk) begin
        run_d1      <= ~thr_stop;
        thr_running <= run_d1;
        core_cmp    <= 1'b0;
        if (inj_valid && inj_ready) req_count <= req_count + 1;
        if (!core_busy && inj_valid && !rdy_q) begin
            rdy_q     <= 1'b1;
            core_insn <= inj_insn;
            core_tid  <= inj_tid;
        end else if (rdy_q) begin
            rdy_q     <= 1'b0;
            core_busy <= 1'b1;
            core_cnt  <= core_lat;
        end else if (core_busy) begin
            if (core_cnt == 0) begin
                core_busy <= 1'b0;
                core_cmp  <= 1'b1;
                core_exc  <= (core_insn[31:28] == 4'hF);
                core_data <= core_res(core_insn, core_tid);
            end else begin
                core_cnt <= core_cnt - 1;
            end
        end
    end

    assign inj_ready = rdy_q;
    assign cmp_valid = core_cmp | stray_cmp;
    assign cmp_exc   = stray_cmp ? 1'b0 : core_exc;
    assign cmp_data  = stray_cmp ? 64'hDEAD_BEEF_0BAD_F00D : core_data;

    task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [63:0] s;
        for (int k = 0; k < 100; k++) begin
            rd(8'h22, s);
            if (s[0]) return;
            @(negedge clk);
        end
    endtask

    localparam int NV = 5;
    localparam logic [31:0] V_INSN [NV] = '{32'h1234_5678, 32'h0BAD_BEEF, 32'hF000_0001, 32'h0000_0000, 32'h7777_7777};
    localparam logic [1:0]  V_TID  [NV] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd3};
    localparam logic [1:0]  V_ERR  [NV] = '{2'b00, 2'b00, 2'b11, 2'b00, 2'b01};

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r, exp_data;
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h22, r);  chk("R1 status after reset", r, 64'h0);
        rd(8'h2E, r);  chk("R1 result after reset", r, 64'h0);
        rd(8'h21, r);  chk("R1 enable after reset", r, 64'h0);
        chk("R1 no request", {63'h0, inj_valid}, 64'h0);
        chk("R1 stop bits", 64'(thr_stop), 64'h0);

        // R5 refused while disabled and threads running
        rc = req_count;
        wr(8'h22, cmd_word(32'hCAFE_0001, 2'd0, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        rd(8'h22, r); chk("R5 disabled refusal status", {61'h0, r[2:0]}, 64'h3);
        chk("R5 disabled no request", 64'(req_count - rc), 64'h0);
        rd(8'h2E, r); chk("R5 disabled data kept", r, 64'h0);

        // R2 stop all threads, R3 enable
        wr(8'h20, 64'h7);
        repeat (3) @(negedge clk);
        rd(8'h20, r); chk("R2 thread ctl readback", r, 64'h0000_0000_0000_0007);
        wr(8'h21, 64'h0000_0000_4000_0000);
        rd(8'h21, r); chk("R3 enable readback", r, 64'h0000_0000_4000_0000);

        // vector table: R4 R6 R7 R5
        exp_data = 64'h0;
        for (int v = 0; v < NV; v++) begin
            rc = req_count;
            wr(8'h22, cmd_word(V_INSN[v], V_TID[v], 1'b1, 1'b1));
            wait_done();
            if (V_ERR[v] == 2'b00) exp_data = core_res(V_INSN[v], V_TID[v]);
            rd(8'h22, r); chk($sformatf("R6 R7 R5 vec%0d status", v), {61'h0, r[2:0]}, {61'h0, V_ERR[v], 1'b1});
            chk($sformatf("R4 vec%0d insn field", v), {32'h0, r[63:32]}, {32'h0, V_INSN[v]});
            rd(8'h2E, r); chk($sformatf("R6 R7 vec%0d result", v), r, exp_data);
            chk($sformatf("R4 vec%0d request count", v), 64'(req_count - rc), (V_ERR[v] == 2'b01) ? 64'h0 : 64'h1);
        end

        // R9 halves
        rd(8'h2F, r); chk("R9 low half view", r, {32'h0, exp_data[31:0]});
        rd(8'h2D, r); chk("R9 high half view", r, {32'h0, exp_data[63:32]});
        wr(8'h2F, 64'hFFFF_FFFF_1357_9BDF);
        wr(8'h2D, 64'h0000_0000_2468_ACE0);
        rd(8'h2E, r); chk("R9 half writes", r, 64'h2468_ACE0_1357_9BDF);
        rd(8'h2F, r); chk("R9 low reserved zero", r, 64'h0000_0000_1357_9BDF);
        exp_data = 64'h2468_ACE0_1357_9BDF;

        // R5 mode bit clear
        wr(8'h22, cmd_word(32'h1111_1111, 2'd0, 1'b0, 1'b1));
        rd(8'h22, r); chk("R5 mode0 refused", {61'h0, r[2:0]}, 64'h3);

        // R5 running thread
        wr(8'h20, 64'h5);
        repeat (3) @(negedge clk);
        rd(8'h20, r); chk("R2 running status", r, 64'h0000_0000_0000_0205);
        rc = req_count;
        wr(8'h22, cmd_word(32'h2222_2222, 2'd1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        rd(8'h22, r); chk("R5 running thread refused", {61'h0, r[2:0]}, 64'h3);
        chk("R5 running no request", 64'(req_count - rc), 64'h0);
        rd(8'h2E, r); chk("R5 running data kept", r, exp_data);

        // R8 second execute while outstanding
        core_lat = 20;
        wr(8'h22, cmd_word(32'h0F0F_1234, 2'd2, 1'b1, 1'b1));
        wr(8'h22, cmd_word(32'h3333_3333, 2'd0, 1'b1, 1'b1));
        rd(8'h22, r); chk("R8 busy status", {61'h0, r[2:0]}, 64'h4);
        chk("R8 insn kept", {32'h0, inj_insn}, {32'h0, 32'h0F0F_1234});
        wait_done();
        rd(8'h22, r); chk("R8 first finishes ok", {61'h0, r[2:0]}, 64'h1);
        exp_data = core_res(32'h0F0F_1234, 2'd2);
        rd(8'h2E, r); chk("R8 first result", r, exp_data);

        // R10 stray completion
        @(negedge clk); stray_cmp = 1'b1;
        @(negedge clk); stray_cmp = 1'b0;
        @(negedge clk);
        rd(8'h2E, r); chk("R10 stray data ignored", r, exp_data);
        rd(8'h22, r); chk("R10 stray status ignored", {61'h0, r[2:0]}, 64'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule